// File: doc/BRIEF.md
# CSMA-CA Backoff Sequencer

This block decides when a low-rate wireless transmitter may put a frame on the air. A start pulse launches an unslotted carrier-sense multiple-access attempt. The sequencer first waits until the receiver reports a valid signal-strength reading. It then draws a random backoff from an internal LFSR and counts that many backoff-period ticks. After the wait it samples the clear-channel flag. A clear channel ends the attempt with a transmit-enable pulse. A busy channel uses up one attempt and widens the backoff window, and the sequencer tries again until no attempts are left.

Three registers hold the loop state: a backoff counter, a working exponent and an attempts counter. The final outcome is read from the attempts counter. A negative retry setting skips channel sensing and grants transmission at once. A separate one-shot request samples the channel a single time and reports the result without transmitting. That request is refused while the receiver is off.

Top module: `csma_seq`

## Requirements
- R1: A start pulse seen while idle loads the exponent with `min_be_i`, the attempts counter with `retries_i`+1, and clears the backoff counter. `busy_o` stays high from the cycle after start until the cycle the done pulse appears. A start or CCA request that arrives while `busy_o` is high has no effect on timing or outcome.
- R2: Before the first backoff, the sequencer holds in place for as long as `rssi_valid_i` is low. Each extra low cycle delays completion by one cycle.
- R3: Each backoff waits a random number of `tick_i` pulses, less than 2^exponent. An exponent of zero gives no wait. The counter advances only on ticks.
- R4: When the channel is clear after the wait, `tx_en_o` and `done_o` pulse together for one cycle. With zero wait and RSSI already valid, this happens 6 cycles after the start sample edge, counting that edge's cycle as 1.
- R5: On a busy channel the attempts counter decrements, and the exponent increments but saturates at `max_be_i`.
- R6: With retries r ≥ 0, a channel that stays busy gives r+1 channel samples. The sequence then ends with `medium_busy_o` and `done_o` pulsing together, and no `tx_en_o`. Each attempt with zero wait takes 3 cycles, so completion is seen at cycle 3(r+1)+3.
- R7: A negative `retries_i` (two's complement) at start makes `tx_en_o` and `done_o` pulse in the next cycle, with no sensing and no busy period.
- R8: A CCA request while `rx_active_i` is high produces `cca_done_o` in the second cycle. `cca_clear_o` equals `cca_clear_i` AND `rssi_valid_i`, sampled one cycle after the request. There is no `tx_en_o` and no `done_o`.
- R9: A CCA request while `rx_active_i` is low produces a one-cycle `cca_err_o` in the next cycle and nothing else.
- R10: `tx_en_o` and `medium_busy_o` are never high together, and each appears only with `done_o`.
- R11: A start and a CCA request in the same idle cycle run the CSMA-CA sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a CSMA-CA attempt |
| cca_req_i | input | 1 | Launch a one-shot channel assessment |
| min_be_i | input | BE_W | Minimum backoff exponent |
| max_be_i | input | BE_W | Maximum backoff exponent |
| retries_i | input | RET_W | Signed retry count, negative bypasses sensing |
| rx_active_i | input | 1 | Receiver is on |
| rssi_valid_i | input | 1 | Signal strength reading valid |
| cca_clear_i | input | 1 | Channel clear indication |
| tick_i | input | 1 | Backoff-period tick |
| busy_o | output | 1 | Sequence in progress |
| tx_en_o | output | 1 | Transmit grant pulse |
| medium_busy_o | output | 1 | Access failure pulse |
| done_o | output | 1 | CSMA-CA completion pulse |
| cca_done_o | output | 1 | One-shot assessment completion pulse |
| cca_clear_o | output | 1 | One-shot assessment result |
| cca_err_o | output | 1 | One-shot request refused |

## Verification
The bench sweeps every retry count with zero exponents and checks the exact completion cycle. An off-by-one in the attempts load or in the decrement shows up there as a three-cycle error, or as a transmit where a failure is expected. Repeated runs with the exponent pinned at one, and then with a widening window, bound the total tick-driven time. A design that forgets the saturation, or that masks the random value wrongly, overruns that bound. The RSSI stall, the start ignored while busy, the negative-retry bypass and all four CCA input combinations are each run with their exact cycle counts. A design that drops the stall, restarts on a second start or forgets the AND with RSSI validity gives a wrong count or a wrong flag.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSSI,
    ST_DRAW,
    ST_WAIT,
    ST_EVAL,
    ST_FINISH,
    ST_CCA
  } seq_state_t;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] state_q;
  logic         fb;

  // Galois form, taps for a maximal-length 16-bit sequence
  assign fb = state_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else begin
      state_q <= (state_q >> 1) ^ (fb ? 16'hB400 : '0);
    end
  end

  assign rnd_o = state_q;
endmodule

// File: rtl/csma_backoff_cnt.sv
module csma_backoff_cnt #(
  parameter int CNT_W = 8,
  parameter int BE_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] rnd_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic             tick_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // Window of 2^be values, all ones once be reaches the counter width
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (32'(be_i) > i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= rnd_i & mask;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/csma_ctrl.sv
module csma_ctrl
  import csma_pkg::*;
#(
  parameter int BE_W  = 4,
  parameter int RET_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cca_req_i,
  input  logic [BE_W-1:0]   min_be_i,
  input  logic [BE_W-1:0]   max_be_i,
  input  logic [RET_W-1:0]  retries_i,
  input  logic              rx_active_i,
  input  logic              rssi_valid_i,
  input  logic              cca_clear_i,
  input  logic              cnt_zero_i,
  output logic              cnt_clear_o,
  output logic              cnt_load_o,
  output logic [BE_W-1:0]   be_o,
  output logic              busy_o,
  output logic              tx_en_o,
  output logic              medium_busy_o,
  output logic              done_o,
  output logic              cca_done_o,
  output logic              cca_clear_o,
  output logic              cca_err_o
);
  seq_state_t       state_q;
  logic [BE_W-1:0]  be_q;
  logic [BE_W-1:0]  max_q;
  logic [RET_W-1:0] att_q;
  logic             neg_retry;

  assign neg_retry   = retries_i[RET_W-1];
  assign be_o        = be_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign cnt_clear_o = (state_q == ST_IDLE) && start_i;
  assign cnt_load_o  = (state_q == ST_DRAW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      be_q          <= '0;
      max_q         <= '0;
      att_q         <= '0;
      tx_en_o       <= 1'b0;
      medium_busy_o <= 1'b0;
      done_o        <= 1'b0;
      cca_done_o    <= 1'b0;
      cca_clear_o   <= 1'b0;
      cca_err_o     <= 1'b0;
    end else begin
      tx_en_o       <= 1'b0;
      medium_busy_o <= 1'b0;
      done_o        <= 1'b0;
      cca_done_o    <= 1'b0;
      cca_err_o     <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (neg_retry) begin
              tx_en_o <= 1'b1;
              done_o  <= 1'b1;
            end else begin
              be_q    <= min_be_i;
              max_q   <= max_be_i;
              att_q   <= retries_i + 1'b1;
              state_q <= ST_RSSI;
            end
          end else if (cca_req_i) begin
            if (rx_active_i) begin
              state_q <= ST_CCA;
            end else begin
              cca_err_o <= 1'b1;
            end
          end
        end
        ST_RSSI: begin
          if (rssi_valid_i) state_q <= ST_DRAW;
        end
        ST_DRAW: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (cnt_zero_i) state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (cca_clear_i) begin
            state_q <= ST_FINISH;
          end else begin
            att_q <= att_q - 1'b1;
            if (be_q < max_q) be_q <= be_q + 1'b1;
            state_q <= (att_q == 1) ? ST_FINISH : ST_DRAW;
          end
        end
        ST_FINISH: begin
          // outcome read from the attempts counter
          done_o        <= 1'b1;
          tx_en_o       <= (att_q != '0);
          medium_busy_o <= (att_q == '0);
          state_q       <= ST_IDLE;
        end
        ST_CCA: begin
          cca_clear_o <= cca_clear_i & rssi_valid_i;
          cca_done_o  <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csma_seq.sv
module csma_seq #(
  parameter int BE_W   = 4,
  parameter int RET_W  = 4,
  parameter int CNT_W  = 8,
  parameter int LFSR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cca_req_i,
  input  logic [BE_W-1:0]  min_be_i,
  input  logic [BE_W-1:0]  max_be_i,
  input  logic [RET_W-1:0] retries_i,
  input  logic             rx_active_i,
  input  logic             rssi_valid_i,
  input  logic             cca_clear_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             tx_en_o,
  output logic             medium_busy_o,
  output logic             done_o,
  output logic             cca_done_o,
  output logic             cca_clear_o,
  output logic             cca_err_o
);
  localparam int RND_W = (CNT_W < LFSR_W) ? CNT_W : LFSR_W;

  logic [LFSR_W-1:0] rnd;
  logic [CNT_W-1:0]  rnd_low;
  logic [BE_W-1:0]   be;
  logic              cnt_clear, cnt_load, cnt_zero;

  assign rnd_low = CNT_W'(rnd[RND_W-1:0]);

  csma_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst(rst), .rnd_o(rnd)
  );

  csma_backoff_cnt #(.CNT_W(CNT_W), .BE_W(BE_W)) u_cnt (
    .clk(clk), .rst(rst), .clear_i(cnt_clear), .load_i(cnt_load),
    .rnd_i(rnd_low), .be_i(be), .tick_i(tick_i), .zero_o(cnt_zero)
  );

  csma_ctrl #(.BE_W(BE_W), .RET_W(RET_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .cca_req_i(cca_req_i),
    .min_be_i(min_be_i), .max_be_i(max_be_i), .retries_i(retries_i),
    .rx_active_i(rx_active_i), .rssi_valid_i(rssi_valid_i),
    .cca_clear_i(cca_clear_i), .cnt_zero_i(cnt_zero),
    .cnt_clear_o(cnt_clear), .cnt_load_o(cnt_load), .be_o(be),
    .busy_o(busy_o), .tx_en_o(tx_en_o), .medium_busy_o(medium_busy_o),
    .done_o(done_o), .cca_done_o(cca_done_o), .cca_clear_o(cca_clear_o),
    .cca_err_o(cca_err_o)
  );
endmodule

// File: rtl/csma_seq_chk.sv
module csma_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic cca_req_i,
  input logic rx_active_i,
  input logic busy_o,
  input logic tx_en_o,
  input logic medium_busy_o,
  input logic done_o,
  input logic cca_done_o,
  input logic cca_err_o
);
  a_r10_outcome_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(tx_en_o && medium_busy_o));
  a_r4_tx_with_done: assert property (@(posedge clk) disable iff (rst)
    tx_en_o |-> done_o);
  a_r6_fail_with_done: assert property (@(posedge clk) disable iff (rst)
    medium_busy_o |-> done_o);
  a_r8_cca_no_tx: assert property (@(posedge clk) disable iff (rst)
    cca_done_o |-> (!tx_en_o && !done_o));
  a_r9_err_rx_off: assert property (@(posedge clk) disable iff (rst)
    cca_err_o |-> !$past(rx_active_i));
  a_r1_busy_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(start_i) || $past(cca_req_i)));
  a_r1_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

bind csma_seq csma_seq_chk i_csma_seq_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .cca_req_i(cca_req_i),
  .rx_active_i(rx_active_i), .busy_o(busy_o), .tx_en_o(tx_en_o),
  .medium_busy_o(medium_busy_o), .done_o(done_o), .cca_done_o(cca_done_o),
  .cca_err_o(cca_err_o)
);

// File: tb/test_csma_seq.sv
module test_csma_seq;
  logic clk = 0, rst = 1;
  logic start_i = 0, cca_req_i = 0, rx_active_i = 0, rssi_valid_i = 0;
  logic cca_clear_i = 0, tick_i = 0;
  logic [3:0] min_be_i = 0, max_be_i = 0, retries_i = 0;
  logic busy_o, tx_en_o, medium_busy_o, done_o, cca_done_o, cca_clear_o, cca_err_o;
  int n_checks = 0, n_fail = 0;
  int dur, n_done, got_tx, got_mb;

  always #2 clk = ~clk;

  csma_seq i_csma_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .cca_req_i(cca_req_i),
    .min_be_i(min_be_i), .max_be_i(max_be_i), .retries_i(retries_i),
    .rx_active_i(rx_active_i), .rssi_valid_i(rssi_valid_i),
    .cca_clear_i(cca_clear_i), .tick_i(tick_i), .busy_o(busy_o),
    .tx_en_o(tx_en_o), .medium_busy_o(medium_busy_o), .done_o(done_o),
    .cca_done_o(cca_done_o), .cca_clear_o(cca_clear_o), .cca_err_o(cca_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one CSMA-CA sequence; cycle 1 is the state after the start edge.
  task automatic run_seq(input int rssi_delay, input int tick_period,
                         input int restart_at, input bit cca_too);
    dur = 0; n_done = 0; got_tx = 0; got_mb = 0;
    rssi_valid_i = (rssi_delay == 0);
    tick_i = 0;
    @(negedge clk);
    start_i = 1; cca_req_i = cca_too;
    for (int c = 1; c < 400; c++) begin
      @(negedge clk);
      start_i = 0; cca_req_i = 0;
      if (c == restart_at) begin start_i = 1; cca_req_i = 1; end
      if (c == rssi_delay) rssi_valid_i = 1;
      tick_i = (tick_period > 0) && (c % tick_period == 0);
      if (cca_done_o) check(0, "R11 cca ran instead", 1, 0);
      if (done_o) begin
        n_done++;
        got_tx = tx_en_o; got_mb = medium_busy_o;
        if (dur == 0) dur = c;
      end
      if (dur != 0 && c >= dur + 8) break;
    end
    start_i = 0; cca_req_i = 0; tick_i = 0;
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy_o && !done_o && !tx_en_o && !medium_busy_o && !cca_done_o && !cca_err_o,
          "R1 reset state", busy_o, 0);

    // R6: busy channel sweep over retry counts, zero exponents
    cca_clear_i = 0;
    for (int r = 0; r < 7; r++) begin
      retries_i = 4'(r);
      run_seq(0, 0, 0, 0);
      check(dur == 3*(r+1)+3, "R6 fail timing", dur, 3*(r+1)+3);
      check(got_mb == 1 && got_tx == 0, "R6 medium busy outcome", got_mb, 1);
      check(n_done == 1, "R6 single done", n_done, 1);
    end

    // R4: clear channel
    cca_clear_i = 1;
    for (int r = 0; r < 3; r++) begin
      retries_i = 4'(r);
      run_seq(0, 0, 0, 0);
      check(dur == 6, "R4 success timing", dur, 6);
      check(got_tx == 1 && got_mb == 0, "R4 transmit outcome", got_tx, 1);
    end

    // R2: RSSI stall
    cca_clear_i = 0; retries_i = 1;
    for (int d = 2; d < 12; d += 3) begin
      run_seq(d, 0, 0, 0);
      check(dur == 9 + d - 1, "R2 rssi stall", dur, 9 + d - 1);
    end

    // R1: start while busy is ignored; R11 start wins over cca
    retries_i = 2;
    run_seq(0, 0, 4, 1);
    check(dur == 12 && n_done == 1, "R1 restart ignored", dur, 12);
    check(got_mb == 1, "R11 start priority outcome", got_mb, 1);

    // R7: negative retries
    retries_i = 4'hF;
    run_seq(0, 0, 0, 0);
    check(dur == 1 && got_tx == 1 && n_done == 1, "R7 bypass", dur, 1);

    // R3/R5: exponent pinned at one, busy channel, 4 attempts, tick every cycle
    min_be_i = 1; max_be_i = 1; retries_i = 3;
    for (int k = 0; k < 20; k++) begin
      run_seq(0, 1, 0, 0);
      check(dur >= 15 && dur <= 15 + 4, "R5 saturated window", dur, 19);
    end
    // R3: widening window 2,3,3 with ticks every 3 cycles
    min_be_i = 2; max_be_i = 3; retries_i = 2;
    for (int k = 0; k < 20; k++) begin
      run_seq(0, 3, 0, 0);
      check(dur >= 12 && dur <= 12 + 3*(3+7+7) + 3, "R3 window bound", dur, 12);
    end
    min_be_i = 0; max_be_i = 0;

    // R8: one-shot CCA, all input combinations
    rx_active_i = 1;
    for (int v = 0; v < 4; v++) begin
      int c_done = 0; int c_res = 0; int c_tx = 0;
      cca_clear_i = v[0]; rssi_valid_i = v[1];
      @(negedge clk); cca_req_i = 1;
      for (int c = 1; c < 5; c++) begin
        @(negedge clk); cca_req_i = 0;
        if (cca_done_o) begin c_done = c; c_res = cca_clear_o; end
        if (tx_en_o || done_o) c_tx = 1;
      end
      check(c_done == 2, "R8 cca timing", c_done, 2);
      check(c_res == (v[0] & v[1]), "R8 cca result", c_res, v[0] & v[1]);
      check(c_tx == 0, "R8 no transmit", c_tx, 0);
    end

    // R9: CCA refused with receiver off
    rx_active_i = 0;
    @(negedge clk); cca_req_i = 1;
    @(negedge clk); cca_req_i = 0;
    check(cca_err_o == 1 && busy_o == 0, "R9 cca error", cca_err_o, 1);
    @(negedge clk);
    check(cca_err_o == 0 && cca_done_o == 0 && busy_o == 0, "R9 single pulse", cca_err_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule